// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two N-bit operands and a carry-in and returns an N-bit sum with a carry-out, all in one combinational path. It does not pass the carry from bit to bit. Each bit position first forms a local generate flag and a local propagate flag. A tree of combining cells then merges these flags over spans that double in size at each level. After log2 N levels the block knows the carry into every bit position. A final XOR stage turns those carries into the sum bits.

The carry-in is treated as an extra position below bit 0. That position generates when the carry-in is set and never propagates. The carry into bit i is therefore the merged generate over all positions from i-1 down to this extra position. The carry-out uses one more merge cell above the tree. The width is a parameter and must be a power of two; 8, 16 and 32 are all supported. The block has no registers, so an embedding pipeline can place it between any two flop stages.

Top module: `prefix_adder`

## Requirements
- R1: `sum_o` equals the low N bits of the unsigned value `a_i + b_i + c_i`.
- R2: `c_o` equals bit N of the unsigned value `a_i + b_i + c_i`.
- R3: When `a_i` is all ones, `b_i` is 1 and `c_i` is 0, `sum_o` is all zeros and `c_o` is 1.
- R4: When both operands are zero, `sum_o` equals `c_i` zero-extended to N bits and `c_o` is 0.
- R5: When `b_i` is the bitwise inverse of `a_i`, the carry-in passes through every bit position: `c_o` equals `c_i`, and every bit of `sum_o` equals the inverse of `c_i`.
- R6: Alternating-bit operands add correctly. With N=8, 0x55 + 0x55 gives sum 0xAA and carry 0. With N=8, 0xAA + 0xAA gives sum 0x54 and carry 1. The same patterns extended to 16 and 32 bits add correctly at those widths.
- R7: The outputs are a purely combinational function of the present inputs. A new operand pair shows up on the outputs within the same clock period, with no cycle of latency.
- R8: Instances built with N = 8, 16 and 32 each meet R1 and R2 at their own width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | first operand |
| b_i | input | N | second operand |
| c_i | input | 1 | carry into bit 0 |
| sum_o | output | N | sum bits |
| c_o | output | 1 | carry out of the top bit |

## Verification
The embedded checks assume the operands and the carry-in hold known 0/1 values. They skip evaluation while any input bit is unknown. The bench meets this assumption by driving every input to zero from time zero. After that it only ever assigns fully defined values, taken from fixed patterns or from `$urandom`. Each new vector is applied just after a rising edge and compared at the following falling edge. The outputs have therefore settled before any check reads them.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] sum_o,
  output logic         c_o
);

  localparam int LV = $clog2(N);

  // gen_q/prp_q index j holds the span ending at bit j-1; index 0 is the carry-in column
  logic [N-1:0] gen_q;
  logic [N-1:0] prp_q;

  always_comb begin
    logic [N-1:0] g, p, gn, pn;
    int k;
    g[0] = c_i;
    p[0] = 1'b0;
    for (int j = 1; j < N; j++) begin
      g[j] = a_i[j-1] & b_i[j-1];
      p[j] = a_i[j-1] | b_i[j-1];
    end
    for (int l = 0; l < LV; l++) begin
      gn = g;
      pn = p;
      for (int j = 0; j < N; j++) begin
        if (((j >> l) & 1) == 1) begin
          k = ((j >> l) << l) - 1;
          gn[j] = g[j] | (p[j] & g[k]);
          pn[j] = p[j] & p[k];
        end
      end
      g = gn;
      p = pn;
    end
    gen_q = g;
    prp_q = p;
  end

  assign sum_o = a_i ^ b_i ^ gen_q;
  assign c_o   = (a_i[N-1] & b_i[N-1]) | ((a_i[N-1] | b_i[N-1]) & gen_q[N-1]);

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1 R2
      full_sum_chk: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (N+1)'(c_i)));
      // R5
      if (a_i == ~b_i)
        prop_chain_chk: assert (c_o == c_i && sum_o == {N{~c_i}});
      // R3
      if (a_i == {N{1'b1}} && b_i == N'(1) && !c_i)
        wrap_chk: assert (sum_o == '0 && c_o);
      // R4
      if (a_i == '0 && b_i == '0)
        cin_only_chk: assert (sum_o == N'(c_i) && !c_o);
    end
  end

endmodule

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [31:0] s32; logic c32;
  logic [15:0] s16; logic c16;
  logic [7:0]  s8;  logic c8;

  int n_run = 0, n_fail = 0;

  prefix_adder #(.N(32)) dut  (.a_i(a),       .b_i(b),       .c_i(cin), .sum_o(s32), .c_o(c32));
  prefix_adder #(.N(16)) dut16(.a_i(a[15:0]), .b_i(b[15:0]), .c_i(cin), .sum_o(s16), .c_o(c16));
  prefix_adder #(.N(8))  dut8 (.a_i(a[7:0]),  .b_i(b[7:0]),  .c_i(cin), .sum_o(s8),  .c_o(c8));

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference: behavioural unsigned addition at each width
  task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] y, input logic ci);
    logic [32:0] r32;
    logic [16:0] r16;
    logic [8:0]  r8;
    @(posedge clk); #1;
    a = x; b = y; cin = ci;
    r32 = {1'b0, x} + {1'b0, y} + 33'(ci);
    r16 = {1'b0, x[15:0]} + {1'b0, y[15:0]} + 17'(ci);
    r8  = {1'b0, x[7:0]} + {1'b0, y[7:0]} + 9'(ci);
    @(negedge clk);
    check({tag, " R1 R2 R7 N32"}, {c32, s32}, r32);
    check({tag, " R8 N16"}, 33'({c16, s16}), 33'(r16));
    check({tag, " R8 N8"},  33'({c8, s8}),   33'(r8));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset-state zero inputs", {c32, s32}, 33'h0);
    // R3 all ones plus one
    apply("R3 wrap", 32'hFFFF_FFFF, 32'h1, 1'b0);
    check("R3 N32 exact", {c32, s32}, {1'b1, 32'h0});
    check("R3 N8 exact", 33'({c8, s8}), 33'h100);
    // R4 zero plus zero with carry-in
    apply("R4 cin only", 32'h0, 32'h0, 1'b1);
    check("R4 N32 exact", {c32, s32}, 33'h1);
    // R5 inverse operands, carry through the full word
    apply("R5 prop cin0", 32'h1234_5678, ~32'h1234_5678, 1'b0);
    check("R5 N32 cin0", {c32, s32}, {1'b0, 32'hFFFF_FFFF});
    apply("R5 prop cin1", 32'h1234_5678, ~32'h1234_5678, 1'b1);
    check("R5 N32 cin1", {c32, s32}, {1'b1, 32'h0});
    // R6 alternating patterns
    apply("R6 5+5", 32'h5555_5555, 32'h5555_5555, 1'b0);
    check("R6 N8 55+55", 33'({c8, s8}), 33'h0AA);
    apply("R6 A+A", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    check("R6 N8 AA+AA", 33'({c8, s8}), 33'h154);
    apply("R6 5+A", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    apply("R6 A+5", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    apply("R1 max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // random vectors
    for (int i = 0; i < 3000; i++)
      apply("R1 rand", $urandom, $urandom, 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule